// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block multiplies two signed fixed-point complex operands, written here as (a + jb) and (c + jd), and returns the exact product. It needs three real multipliers instead of four: a pre-add stage forms a + b, d − c and c + d, and a post-add stage recombines the three partial products into the real and imaginary results. Each of the three arithmetic steps has its own register stage, so every multiplier is registered on both sides. A new operand pair is accepted on every clock.

Each operand part is W bits of two's complement. The pre-add sums are W+1 bits wide. Every partial product and both outputs are 2W+2 bits wide, so no combination of inputs can overflow. A valid flag runs through a three-deep shift register beside the data and marks which output words hold a product. The flag pipeline has a synchronous active-high reset. The data registers have none.

Top module: `cplx3_mul`

## Requirements
- R1: When `out_valid` is high, `out_re` equals a·c − b·d for the operands sampled three rising edges earlier, sign-extended to 2W+2 bits with no rounding or truncation.
- R2: When `out_valid` is high, `out_im` equals a·d + b·c for the same operands, sign-extended to 2W+2 bits.
- R3: An operand set sampled with `in_valid` high at rising edge k makes `out_valid` high, with its product on the outputs, right after rising edge k+2. The latency is three edges counted from the sampling edge.
- R4: Operand sets presented on consecutive clocks come out on consecutive clocks, in order and with no gaps. This is one product per clock.
- R5: An edge at which `in_valid` is low yields `out_valid` low three edges later, whatever data sits on the operand inputs.
- R6: The extreme operand values give exact results. With all parts at −2^(W−1), the real part is 0 and the imaginary part is 2^(2W−1). Mixed maximum-positive and maximum-negative parts also give the exact value.
- R7: A rising edge with `rst` high makes `out_valid` low on the next cycle. Operands accepted before or during reset never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks the operand inputs as holding a set to multiply |
| in_a | input | W | Real part of the first operand, signed |
| in_b | input | W | Imaginary part of the first operand, signed |
| in_c | input | W | Real part of the second operand, signed |
| in_d | input | W | Imaginary part of the second operand, signed |
| out_valid | output | 1 | Marks `out_re`/`out_im` as holding a product |
| out_re | output | 2W+2 | Real part of the product, signed |
| out_im | output | 2W+2 | Imaginary part of the product, signed |

## Verification
Random operand sets sent back to back test the arithmetic and the one-per-clock flow. A wrong pre-add sign or a wrong post-add term shows up as a mismatch against a plain four-product reference. Sets made only of maximum-negative and maximum-positive parts find sign-extension and width mistakes that random values rarely reach. Sparse traffic mixed with idle cycles carrying junk data shows whether the valid flag stays aligned with its data. A reset that lands while products are still in flight shows whether the pipeline drops them.

// File: rtl/cplx3_mul_pkg.sv
package cplx3_mul_pkg;
  // register stages between operand input and product output
  localparam int unsigned STAGES = 3;
  // number of real multipliers in the middle stage
  localparam int unsigned NUM_MULT = 3;

  function automatic int unsigned pre_width(input int unsigned w);
    return w + 1;
  endfunction

  function automatic int unsigned prod_width(input int unsigned w);
    return 2 * w + 2;
  endfunction
endpackage

// File: rtl/cplx3_preadd.sv
// Stage 1: forms the pre-add/pre-subtract terms and lines up the factor pairs
// for the three multipliers. Pair 0: (a+b, c), pair 1: (a, d-c), pair 2: (b, c+d).
module cplx3_preadd
  import cplx3_mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                            clk,
  input  logic signed [W-1:0]             op_a,
  input  logic signed [W-1:0]             op_b,
  input  logic signed [W-1:0]             op_c,
  input  logic signed [W-1:0]             op_d,
  output logic signed [pre_width(W)-1:0]  fac_x [NUM_MULT],
  output logic signed [pre_width(W)-1:0]  fac_y [NUM_MULT]
);
  localparam int unsigned EW = pre_width(W);

  logic signed [EW-1:0] ea, eb, ec, ed;

  always_comb begin
    ea = EW'(op_a);
    eb = EW'(op_b);
    ec = EW'(op_c);
    ed = EW'(op_d);
  end

  always_ff @(posedge clk) begin
    fac_x[0] <= ea + eb;
    fac_y[0] <= ec;
    fac_x[1] <= ea;
    fac_y[1] <= ed - ec;
    fac_x[2] <= eb;
    fac_y[2] <= ec + ed;
  end
endmodule

// File: rtl/cplx3_mult.sv
// Stage 2: the three real multipliers, each registered on its own.
module cplx3_mult
  import cplx3_mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                             clk,
  input  logic signed [pre_width(W)-1:0]   fac_x [NUM_MULT],
  input  logic signed [pre_width(W)-1:0]   fac_y [NUM_MULT],
  output logic signed [prod_width(W)-1:0]  prod  [NUM_MULT]
);
  localparam int unsigned PW = prod_width(W);

  for (genvar g = 0; g < NUM_MULT; g++) begin : g_mul
    logic signed [PW-1:0] wx, wy;
    always_comb begin
      wx = PW'(fac_x[g]);
      wy = PW'(fac_y[g]);
    end
    always_ff @(posedge clk) begin
      prod[g] <= wx * wy;
    end
  end
endmodule

// File: rtl/cplx3_postadd.sv
// Stage 3: recombines the products. k0=c(a+b), k1=a(d-c), k2=b(c+d).
module cplx3_postadd
  import cplx3_mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                             clk,
  input  logic signed [prod_width(W)-1:0]  prod [NUM_MULT],
  output logic signed [prod_width(W)-1:0]  res_re,
  output logic signed [prod_width(W)-1:0]  res_im
);
  always_ff @(posedge clk) begin
    res_re <= prod[0] - prod[2];
    res_im <= prod[0] + prod[1];
  end
endmodule

// File: rtl/cplx3_vpipe.sv
// Valid flag delay line, one bit per arithmetic stage.
module cplx3_vpipe
  import cplx3_mul_pkg::*;
#(
  parameter int unsigned DEPTH = STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  output logic v_out
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], v_in};
  end

  assign v_out = sr[DEPTH-1];

  // R7: a reset edge empties the output flag on the next cycle
  a_r7_reset_clears: assert property (@(posedge clk) rst |=> !v_out);
endmodule

// File: rtl/cplx3_mul.sv
module cplx3_mul
  import cplx3_mul_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic signed [W-1:0]             in_a,
  input  logic signed [W-1:0]             in_b,
  input  logic signed [W-1:0]             in_c,
  input  logic signed [W-1:0]             in_d,
  output logic                            out_valid,
  output logic signed [2*W+1:0]           out_re,
  output logic signed [2*W+1:0]           out_im
);
  localparam int unsigned EW = pre_width(W);
  localparam int unsigned PW = prod_width(W);

  logic signed [EW-1:0] fac_x [NUM_MULT];
  logic signed [EW-1:0] fac_y [NUM_MULT];
  logic signed [PW-1:0] prod  [NUM_MULT];

  cplx3_preadd #(.W(W)) u_pre (
    .clk(clk), .op_a(in_a), .op_b(in_b), .op_c(in_c), .op_d(in_d),
    .fac_x(fac_x), .fac_y(fac_y)
  );

  cplx3_mult #(.W(W)) u_mul (
    .clk(clk), .fac_x(fac_x), .fac_y(fac_y), .prod(prod)
  );

  cplx3_postadd #(.W(W)) u_post (
    .clk(clk), .prod(prod), .res_re(out_re), .res_im(out_im)
  );

  cplx3_vpipe #(.DEPTH(STAGES)) u_vld (
    .clk(clk), .rst(rst), .v_in(in_valid), .v_out(out_valid)
  );

  // Direct four-product form, used only by the end-to-end checks below.
  logic signed [PW-1:0] chk_re, chk_im;
  always_comb begin
    chk_re = PW'(in_a) * PW'(in_c) - PW'(in_b) * PW'(in_d);
    chk_im = PW'(in_a) * PW'(in_d) + PW'(in_b) * PW'(in_c);
  end

  a_r1_real_exact: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_re == $past(chk_re, 3));
  a_r2_imag_exact: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_im == $past(chk_im, 3));
  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid);
endmodule

// File: tb/cplx3_mul_tb_top.sv
module cplx3_mul_tb_top;
  localparam int unsigned W  = 16;
  localparam int unsigned PW = 2 * W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic out_valid;
  logic signed [PW-1:0] out_re, out_im;

  always #2 clk = ~clk;  // 250 MHz

  cplx3_mul #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  typedef struct {
    logic signed [PW-1:0] re;
    logic signed [PW-1:0] im;
    int                   due;
    string                tag;
  } exp_t;

  exp_t scb[$];
  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;
  bit done = 0;

  localparam logic signed [W-1:0] MAXN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  always @(posedge clk) edges <= edges + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // driver: one operand set per call, expected result computed with four products
  task automatic drive(input logic signed [W-1:0] a, b, c, d, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_d = d;
    e.re  = PW'(longint'(a) * longint'(c) - longint'(b) * longint'(d));
    e.im  = PW'(longint'(a) * longint'(d) + longint'(b) * longint'(c));
    e.due = edges + 3;
    e.tag = tag;
    scb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = W'($urandom); in_b = W'($urandom); in_c = W'($urandom); in_d = W'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (scb.size() == 0) begin
        check(1'b0, "R5 R7 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = scb.pop_front();
        check(edges == e.due, "R3 R4 output cycle", edges, e.due);
        check(out_re == e.re, {"R1 real ", e.tag}, out_re, e.re);
        check(out_im == e.im, {"R2 imag ", e.tag}, out_im, e.im);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected drain");
    finish_run();
  end

  task automatic drain;
    for (int i = 0; i < 10 && scb.size() != 0; i++) @(negedge clk);
    check(scb.size() == 0, "R3 pending results", scb.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset state", out_valid, 0);
    rst = 1'b0;

    // R4: back-to-back random sets
    for (int i = 0; i < 200; i++)
      drive(W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R4 burst");
    idle(1);
    drain();

    // R6: extreme corners
    drive(MAXN, MAXN, MAXN, MAXN, "R6 all-neg");
    drive(MAXP, MAXP, MAXP, MAXP, "R6 all-pos");
    drive(MAXN, MAXP, MAXN, MAXP, "R6 mixA");
    drive(MAXP, MAXN, MAXN, MAXP, "R6 mixB");
    drive(MAXN, MAXN, MAXP, MAXN, "R6 mixC");
    drive(MAXN, '0, MAXN, '0, "R6 real-only");
    drive('0, MAXN, '0, MAXN, "R6 imag-only");
    idle(1);
    drain();
    // R6 explicit value for all-negative parts
    drive(MAXN, MAXN, MAXN, MAXN, "R6 literal");
    idle(2);
    @(negedge clk);
    check(out_re == 0, "R6 literal real", out_re, 0);
    check(out_im == (PW'(1) <<< (2*W-1)), "R6 literal imag", out_im, longint'(1) <<< (2*W-1));
    drain();

    // R5: sparse traffic with junk on idle cycles
    for (int i = 0; i < 60; i++) begin
      drive(W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R5 sparse");
      idle(int'($urandom_range(0, 3)));
    end
    idle(1);
    drain();

    // R7: reset while products are in flight
    drive(W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R7 flushed");
    drive(W'($urandom), W'($urandom), W'($urandom), W'($urandom), "R7 flushed");
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    scb.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R7 flush", out_valid, 0);
    in_valid = 1'b0; rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 no stale output", out_valid, 0);
    end

    drive(W'(3), W'(-4), W'(5), W'(2), "R1 small");
    idle(4);
    drain();
    finish_run();
  end
endmodule